// File: doc/BRIEF.md
# Configurable PLD Output Macrocell

This block is a single output cell of a sum-of-products programmable logic device. It ORs a bank of product terms into a sum term, optionally stores that sum in a flip-flop on the global clock, applies a selectable output polarity, and drives a tri-state pin as a value plus an enable. The enable can come from a dedicated enable product term or from an enable pin shared by all cells. The cell also returns a feedback signal to the logic array.

Three configuration bits give eight cell configurations. `cfg_i[2]` selects the enable source. `cfg_i[1]` chooses between the registered and the combinatorial path. `cfg_i[0]` sets the polarity. The all-zero value is the unprogrammed default: registered, active low, with the enable taken from the product term. For test, a preload port writes any chosen value into the flip-flop, whatever the array presents.

Top module: `plc_macrocell`

## Requirements
- R1: The sum term is the OR of the `NUM_PT` (default 8) bits of `pt_i`. With `cfg_i` = 3'b011 or 3'b111 (combinatorial, active high), `pad_out_o` equals that OR in the same cycle.
- R2: `oe_pt_i` never contributes to the sum term. With every `pt_i` bit at 0, the combinatorial active-high output is 0 whatever the level of `oe_pt_i`.
- R3: With `cfg_i[1]` = 0 (registered), the pin value comes from the flip-flop. The flip-flop takes the sum term on each rising edge of `clk` when `preload_en_i` is 0, and the pin shows it from that edge onward.
- R4: With `cfg_i[1]` = 1 (combinatorial), the pin value follows the sum term with no clock edge in the path.
- R5: With `cfg_i[0]` = 0 (active low), the driven value is the inverse of the selected source. With `cfg_i[0]` = 1 (active high), it is the source unchanged.
- R6: `pad_oe_o` equals `oe_pt_i` when `cfg_i[2]` = 0 and equals the active-high shared pin `oe_pin_i` when `cfg_i[2]` = 1.
- R7: While `rst_n` is low (power-up), the flip-flop holds 0. With `cfg_i` = 3'b000, this gives `pad_out_o` = 1 and `fb_o` = 0.
- R8: When `preload_en_i` is 1 at a rising clock edge, the flip-flop loads `preload_val_i` in place of the sum term. This works in every configuration.
- R9: In registered mode, `fb_o` is the flip-flop output (true polarity). In combinatorial mode, `fb_o` is the pin level `pad_in_i`, so with the enable inactive the pin serves as a plain input.
- R10: In combinatorial mode the flip-flop keeps capturing on every edge. Switching back to registered mode shows the value captured at the last edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock shared by all cells |
| rst_n | input | 1 | Active-low power-up reset; clears the flip-flop |
| pt_i | input | NUM_PT | Product terms feeding the sum term |
| oe_pt_i | input | 1 | Enable product term |
| oe_pin_i | input | 1 | Shared external enable, active high |
| cfg_i | input | 3 | [2] enable source, [1] comb/reg, [0] polarity |
| preload_en_i | input | 1 | Preload strobe for the flip-flop |
| preload_val_i | input | 1 | Value written by preload |
| pad_in_i | input | 1 | Level seen on the pin, for pin feedback |
| pad_out_o | output | 1 | Value driven onto the pin |
| pad_oe_o | output | 1 | Pin driver enable (0 = high impedance) |
| fb_o | output | 1 | Feedback to the logic array |

## Verification
The enable, the feedback and the combinatorial pin value are due in the same cycle as the input that causes them. The registered pin value and preload take effect one rising edge after they are applied. The bench sets inputs on the falling edge and compares all three outputs a quarter period later. It moves its own flip-flop model on the rising edge between two comparisons, so each registered result is checked in the first cycle it becomes valid. A mode switch from combinatorial to registered exposes the value captured while the pin was bypassing the flip-flop.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

  // Field order matches cfg_i[2:0]: enable source, path mode, polarity.
  typedef struct packed {
    logic oe_from_pin;
    logic comb;
    logic active_high;
  } cell_cfg_t;

  localparam int CFG_W = $bits(cell_cfg_t);

  function automatic logic apply_polarity(input logic v, input logic active_high);
    return active_high ? v : ~v;
  endfunction

  function automatic logic pick_enable(input logic from_pin, input logic pt_en,
                                       input logic pin_en);
    return from_pin ? pin_en : pt_en;
  endfunction

  function automatic logic pick_source(input logic comb, input logic sum,
                                       input logic q);
    return comb ? sum : q;
  endfunction

  function automatic logic pick_feedback(input logic comb, input logic pad,
                                         input logic q);
    return comb ? pad : q;
  endfunction

endpackage

// File: rtl/mcell_sum_term.sv
module mcell_sum_term #(
  parameter int NUM_PT = 8
) (
  input  logic [NUM_PT-1:0] pt_i,
  output logic              sum_o
);
  localparam int CHAIN_W = NUM_PT + 1;

  logic [CHAIN_W-1:0] or_chain;

  assign or_chain[0] = 1'b0;

  for (genvar g = 0; g < NUM_PT; g++) begin : g_or
    assign or_chain[g+1] = or_chain[g] | pt_i[g];
  end

  assign sum_o = or_chain[CHAIN_W-1];

endmodule

// File: rtl/mcell_state_reg.sv
module mcell_state_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  input  logic pl_en_i,
  input  logic pl_val_i,
  output logic q_o
);
  logic take_preload;
  logic take_array;
  logic next_q;

  assign take_preload = pl_en_i;
  assign take_array   = ~pl_en_i;

  always_comb begin
    next_q = d_i;
    if (take_preload) next_q = pl_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= next_q;
  end

  p_array_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_array |=> (q_o == $past(d_i)));

  p_preload_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_preload |=> (q_o == $past(pl_val_i)));

endmodule

// File: rtl/mcell_out_select.sv
module mcell_out_select
  import mcell_pkg::*;
(
  input  cell_cfg_t cfg_i,
  input  logic      sum_i,
  input  logic      q_i,
  input  logic      oe_pt_i,
  input  logic      oe_pin_i,
  input  logic      pad_in_i,
  output logic      pad_out_o,
  output logic      pad_oe_o,
  output logic      fb_o
);
  logic src_val;

  assign src_val   = pick_source(cfg_i.comb, sum_i, q_i);
  assign pad_out_o = apply_polarity(src_val, cfg_i.active_high);
  assign pad_oe_o  = pick_enable(cfg_i.oe_from_pin, oe_pt_i, oe_pin_i);
  assign fb_o      = pick_feedback(cfg_i.comb, pad_in_i, q_i);

endmodule

// File: rtl/plc_macrocell.sv
module plc_macrocell
  import mcell_pkg::*;
#(
  parameter int NUM_PT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_PT-1:0] pt_i,
  input  logic              oe_pt_i,
  input  logic              oe_pin_i,
  input  logic [2:0]        cfg_i,
  input  logic              preload_en_i,
  input  logic              preload_val_i,
  input  logic              pad_in_i,
  output logic              pad_out_o,
  output logic              pad_oe_o,
  output logic              fb_o
);
  cell_cfg_t cfg;
  logic      sum_term;
  logic      reg_q;

  assign cfg = cell_cfg_t'(cfg_i);

  mcell_sum_term #(.NUM_PT(NUM_PT)) u_sum (
    .pt_i  (pt_i),
    .sum_o (sum_term)
  );

  mcell_state_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .d_i      (sum_term),
    .pl_en_i  (preload_en_i),
    .pl_val_i (preload_val_i),
    .q_o      (reg_q)
  );

  mcell_out_select u_sel (
    .cfg_i     (cfg),
    .sum_i     (sum_term),
    .q_i       (reg_q),
    .oe_pt_i   (oe_pt_i),
    .oe_pin_i  (oe_pin_i),
    .pad_in_i  (pad_in_i),
    .pad_out_o (pad_out_o),
    .pad_oe_o  (pad_oe_o),
    .fb_o      (fb_o)
  );

  p_comb_follows_pt_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i[1] && cfg_i[0]) |-> (pad_out_o == (pt_i != '0)));

  p_enable_pt_not_in_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i[1] && cfg_i[0] && pt_i == '0) |-> !pad_out_o);

  p_low_polarity_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_i[1] && !cfg_i[0]) |-> (pad_out_o != fb_o));

  p_pin_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_i[2] |-> (pad_oe_o == oe_pin_i));

  p_pt_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_i[2] |-> (pad_oe_o == oe_pt_i));

  p_pin_feedback_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_i[1] |-> (fb_o == pad_in_i));

  p_reg_feedback_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_i[1] |-> (fb_o == reg_q));

endmodule

// File: tb/plc_macrocell_bench.sv
module plc_macrocell_bench;
  localparam int NPT = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NPT-1:0] pt = '0;
  logic           oe_pt = 1'b0;
  logic           oe_pin = 1'b0;
  logic [2:0]     cfg = 3'b000;
  logic           pl_en = 1'b0;
  logic           pl_val = 1'b0;
  logic           pad_in = 1'b0;
  logic           pad_out, pad_oe, fb;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  bit model_q = 0;
  int seed = 32'h1234_5678;

  always #10 clk = ~clk;

  plc_macrocell #(.NUM_PT(NPT)) u_plc_macrocell (
    .clk(clk), .rst_n(rst_n), .pt_i(pt), .oe_pt_i(oe_pt), .oe_pin_i(oe_pin),
    .cfg_i(cfg), .preload_en_i(pl_en), .preload_val_i(pl_val), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .fb_o(fb)
  );

  function automatic bit model_sum(input logic [NPT-1:0] v);
    int ones = 0;
    for (int i = 0; i < NPT; i++) if (v[i]) ones++;
    return ones > 0;
  endfunction

  task automatic check1(input string tag, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b (cfg=%b pt=%h t=%0t)",
               tag, what, act, exp, cfg, pt, $time);
    end
  endtask

  task automatic compare(input string tag);
    bit src, exp_out, exp_oe, exp_fb;
    src     = cfg[1] ? model_sum(pt) : model_q;
    exp_out = cfg[0] ? src : !src;
    exp_oe  = cfg[2] ? oe_pin : oe_pt;
    exp_fb  = cfg[1] ? pad_in : model_q;
    check1(tag, "pad_out", pad_out, exp_out);
    check1(tag, "pad_oe", pad_oe, exp_oe);
    check1(tag, "fb", fb, exp_fb);
  endtask

  // Apply on falling edge, compare 5 ns later, advance model on rising edge.
  task automatic step(input string tag, input logic [2:0] c, input logic [NPT-1:0] p,
                      input logic ope, input logic opin, input logic ple,
                      input logic plv, input logic pin);
    @(negedge clk);
    cfg = c; pt = p; oe_pt = ope; oe_pin = opin; pl_en = ple; pl_val = plv; pad_in = pin;
    #5;
    compare(tag);
    @(posedge clk);
    model_q = ple ? plv : model_sum(p);
  endtask

  function automatic int next_rand(input int s);
    return s * 1103515245 + 12345;
  endfunction

  initial begin
    #4_000_000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R7: reset state with unprogrammed configuration
    repeat (2) @(negedge clk);
    #5;
    check1("R7", "pad_out", pad_out, 1'b1);
    check1("R7", "fb", fb, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    model_q = 0;

    // R3: registered capture, default configuration
    step("R3", 3'b000, 8'h00, 1, 0, 0, 0, 0);
    step("R3", 3'b000, 8'h10, 1, 0, 0, 0, 0);
    step("R3", 3'b001, 8'h00, 1, 0, 0, 0, 0);
    step("R3", 3'b001, 8'h00, 0, 1, 0, 0, 1);

    // R1/R4: each product term alone reaches the pin combinatorially
    for (int b = 0; b < NPT; b++) begin
      step("R1", 3'b011, 8'(1 << b), 0, 0, 0, 0, 0);
      step("R4", 3'b010, 8'(1 << b), 1, 0, 0, 0, 1);
    end

    // R2: enable term alone does not set the sum
    step("R2", 3'b011, 8'h00, 1, 0, 0, 0, 0);
    step("R2", 3'b111, 8'h00, 1, 1, 0, 0, 0);

    // R8: preload beats the array in several modes
    step("R8", 3'b000, 8'hFF, 0, 0, 1, 0, 0);
    step("R8", 3'b000, 8'h00, 0, 0, 1, 1, 0);
    step("R8", 3'b001, 8'h00, 0, 0, 0, 0, 0);
    step("R8", 3'b011, 8'h00, 0, 0, 1, 1, 1);
    step("R8", 3'b001, 8'hFF, 0, 0, 1, 0, 0);
    step("R8", 3'b001, 8'h00, 0, 0, 0, 0, 0);

    // R10: capture continues in combinatorial mode, seen after switch back
    step("R10", 3'b011, 8'h40, 0, 0, 0, 0, 0);
    step("R10", 3'b001, 8'h00, 0, 0, 0, 0, 0);
    step("R10", 3'b010, 8'h00, 0, 0, 0, 0, 1);
    step("R10", 3'b000, 8'h00, 0, 0, 0, 0, 0);

    // R6/R9: enable source and feedback across pin levels
    step("R6", 3'b100, 8'h01, 0, 1, 0, 0, 0);
    step("R6", 3'b100, 8'h01, 1, 0, 0, 0, 0);
    step("R9", 3'b110, 8'h00, 1, 0, 0, 0, 1);
    step("R9", 3'b111, 8'hFF, 0, 0, 0, 0, 0);

    // R5 and all eight configurations under mixed patterns
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 40; k++) begin
        logic [NPT-1:0] p;
        seed = next_rand(seed);
        p = (seed[20] && seed[21]) ? '0 : seed[NPT+7:8];
        step("R5", 3'(c), p, seed[3], seed[4], seed[29] && seed[30], seed[5], seed[6]);
      end
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule